// File: doc/BRIEF.md
# Error Report Header Logging Sequencer

This block sits on the application side of a PCIe endpoint. It passes transaction errors to the transaction-layer core through a 7-bit error-flag vector. An error request carries a 2-bit error kind, a log-enable bit and a 128-bit TLP header. When logging is enabled, the sequencer first writes the header into the core's error-descriptor registers. It does this as four 32-bit writes on a small management write port (address, data, write strobe, acknowledge). Only after the fourth acknowledge does it raise the selected error bit, and in that same cycle it raises the log-header bit. When logging is disabled, it raises the error bit alone and does no writes.

The block is a four-state machine:
- **IDLE** accepts a request. It goes to WRITE when logging is enabled and to FLAG when it is not.
- **WRITE** issues the header words in turn. It advances the word index on each acknowledge and goes to FLAG after the acknowledge of the last word.
- **FLAG** drives the error flags for one cycle and then goes to DONE.
- **DONE** pulses `done` and then returns to IDLE.

Separately from the state machine, a saturating counter tracks non-posted requests that are still waiting for their completions. It drives a completion-pending level from that count.

Top module: `errlog_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done`, `mgmt_wr`, `cpl_pend` and every bit of `err_flags` are low.
- R2: A request on `req_valid` is accepted only when `busy` is low. `busy` is high in every state but IDLE, and a `req_valid` seen while busy changes neither the writes nor the flags of the running report.
- R3: With `req_log`=1, four writes are issued in ascending address order. Address 12'h81C carries header bits [127:96], 12'h820 carries [95:64], 12'h824 carries [63:32] and 12'h828 carries [31:0]. The first write is presented in the cycle after acceptance.
- R4: A write keeps `mgmt_wr`, `mgmt_addr` and `mgmt_wdata` constant until a cycle in which `mgmt_ack` is high. The next word is presented in the following cycle.
- R5: With logging, `err_flags` stays zero until the fourth write is acknowledged. In the following cycle, the selected error bit and bit 6 (log header) are both high, for exactly one cycle, and `mgmt_wr` is low.
- R6: `req_kind` values 0, 1, 2 and 3 select error bits 2, 3, 4 and 5 (bit 4 is unsupported request on a posted TLP, bit 5 is unsupported request on a non-posted TLP). At most one of bits 2 to 5 is ever high, and bits 0 and 1 are always low.
- R7: With `req_log`=0, no write is issued. The selected error bit alone is high for one cycle, in the cycle after acceptance.
- R8: `done` is high for exactly one cycle, in the cycle after the flag cycle. `busy` is low in the cycle after that.
- R9: The outstanding count rises by one on `np_issue` and falls by one on `np_cpl`, and it is unchanged when both are high. `cpl_pend` is high exactly when the count is nonzero.
- R10: The count saturates at its maximum (15 with the default width of 4) and at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Error report request |
| req_kind | input | 2 | Error kind, 0..3 selects flag bit 2..5 |
| req_log | input | 1 | Write the header and raise the log-header flag |
| req_hdr | input | 128 | TLP header to log |
| busy | output | 1 | High outside IDLE |
| done | output | 1 | One-cycle end-of-report pulse |
| mgmt_addr | output | 12 | Management write address |
| mgmt_wdata | output | 32 | Management write data |
| mgmt_wr | output | 1 | Management write strobe |
| mgmt_ack | input | 1 | Management write acknowledge |
| err_flags | output | 7 | Error flags to the core; bit 6 is log header |
| np_issue | input | 1 | A non-posted request was issued |
| np_cpl | input | 1 | A completion was received |
| cpl_pend | output | 1 | Completions outstanding |

## Verification
Logged reports are driven with acknowledges that come back at once, and with acknowledges that come back after several wait cycles. The first pattern shows whether words advance on every acknowledge. The second shows whether address and data are held while waiting, and whether the flags wait for the last acknowledge rather than for a fixed cycle count. Unlogged reports for two other kinds separate the skip path and the kind-to-bit mapping from the logged path. A stray `req_valid` kept high during a busy report shows whether requests are ignored while the block is busy. The counter is driven past its top, below zero, and with both strobes together. Each of these gives a pending level that differs from the one a wrapping counter or an unguarded counter would give.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FLAG  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

    localparam int FLAG_W   = 7;
    localparam int ERR_LO   = 2;
    localparam int LOG_BIT  = 6;
    localparam int KIND_W   = 2;
endpackage

// File: rtl/errlog_pend_counter.sv
module errlog_pend_counter #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic np_issue,
    input  logic np_cpl,
    output logic cpl_pend
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (np_issue && !np_cpl && cnt_q != MAXV) begin
            cnt_q <= cnt_q + ONE;
        end else if (np_cpl && !np_issue && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cpl_pend = (cnt_q != '0);

    // R9: a lone issue strobe below the top adds exactly one
    assert_cnt_inc_R9: assert property (@(posedge clk) disable iff (rst)
        (np_issue && !np_cpl && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + ONE));
    // R10: saturation at the top and at zero
    assert_cnt_sat_top_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == MAXV && !np_cpl) |=> (cnt_q == MAXV));
    assert_cnt_sat_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !np_issue) |=> (cnt_q == '0));
endmodule

// File: rtl/errlog_hdr_mux.sv
module errlog_hdr_mux #(
    parameter int DATA_W    = 32,
    parameter int WORDS     = 4,
    parameter int ADDR_W    = 12,
    parameter logic [11:0] BASE_ADDR = 12'h81C,
    parameter int ADDR_STEP = 4,
    localparam int HDR_W    = DATA_W * WORDS,
    localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [HDR_W-1:0]  hdr,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word,
    output logic [ADDR_W-1:0] addr
);
    logic [DATA_W-1:0] words [WORDS];

    // word 0 is the most significant slice of the header
    for (genvar k = 0; k < WORDS; k++) begin : g_slice
        assign words[k] = hdr[HDR_W-1-k*DATA_W -: DATA_W];
    end

    assign word = words[idx];
    assign addr = ADDR_W'(BASE_ADDR) + ADDR_W'(idx) * ADDR_W'(ADDR_STEP);
endmodule

// File: rtl/errlog_seq_fsm.sv
module errlog_seq_fsm
    import errlog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    localparam int HDR_W = DATA_W * WORDS,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic              req_log,
    input  logic [HDR_W-1:0]  req_hdr,
    input  logic              mgmt_ack,
    output logic [IDX_W-1:0]  word_idx,
    output logic [HDR_W-1:0]  hdr_q,
    output logic              mgmt_wr,
    output logic              busy,
    output logic              done,
    output logic [FLAG_W-1:0] err_flags
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    seq_state_t        state_q, state_d;
    logic [KIND_W-1:0] kind_q;
    logic              log_q;
    logic [IDX_W-1:0]  idx_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = req_log ? ST_WRITE : ST_FLAG;
            ST_WRITE: if (mgmt_ack && idx_q == LAST_IDX) state_d = ST_FLAG;
            ST_FLAG:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= '0;
            log_q   <= 1'b0;
            idx_q   <= '0;
            hdr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                kind_q <= req_kind;
                log_q  <= req_log;
                hdr_q  <= req_hdr;
                idx_q  <= '0;
            end else if (state_q == ST_WRITE && mgmt_ack && idx_q != LAST_IDX) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        mgmt_wr   = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        err_flags = '0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_WRITE: mgmt_wr = 1'b1;
            ST_FLAG: begin
                err_flags[ERR_LO + int'(kind_q)] = 1'b1;
                err_flags[LOG_BIT]               = log_q;
            end
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    assign word_idx = idx_q;

    // R5: log-header flag never appears without an error bit
    assert_log_with_err_R5: assert property (@(posedge clk) disable iff (rst)
        err_flags[LOG_BIT] |-> (|err_flags[ERR_LO+3:ERR_LO]));
    // R5: flags last a single cycle
    assert_flag_single_R5: assert property (@(posedge clk) disable iff (rst)
        (|err_flags) |=> (err_flags == '0));
    // R6: one error bit at most, low bits never used
    assert_err_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(err_flags[ERR_LO+3:ERR_LO]) && err_flags[1:0] == 2'b00);
    // R8: done is a single-cycle pulse after the flag cycle
    assert_done_after_flag_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(|err_flags));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);
    // R2: no write strobe outside a running report
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mgmt_wr && err_flags == '0));
endmodule

// File: rtl/errlog_seq.sv
module errlog_seq
    import errlog_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int WORDS     = 4,
    parameter int ADDR_W    = 12,
    parameter logic [11:0] BASE_ADDR = 12'h81C,
    parameter int ADDR_STEP = 4,
    parameter int CNT_W     = 4,
    localparam int HDR_W    = DATA_W * WORDS,
    localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_log,
    input  logic [HDR_W-1:0]  req_hdr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mgmt_addr,
    output logic [DATA_W-1:0] mgmt_wdata,
    output logic              mgmt_wr,
    input  logic              mgmt_ack,
    output logic [6:0]        err_flags,
    input  logic              np_issue,
    input  logic              np_cpl,
    output logic              cpl_pend
);
    logic [IDX_W-1:0] word_idx;
    logic [HDR_W-1:0] hdr_q;

    errlog_seq_fsm #(.DATA_W(DATA_W), .WORDS(WORDS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_log   (req_log),
        .req_hdr   (req_hdr),
        .mgmt_ack  (mgmt_ack),
        .word_idx  (word_idx),
        .hdr_q     (hdr_q),
        .mgmt_wr   (mgmt_wr),
        .busy      (busy),
        .done      (done),
        .err_flags (err_flags)
    );

    errlog_hdr_mux #(
        .DATA_W(DATA_W), .WORDS(WORDS), .ADDR_W(ADDR_W),
        .BASE_ADDR(BASE_ADDR), .ADDR_STEP(ADDR_STEP)
    ) u_mux (
        .hdr  (hdr_q),
        .idx  (word_idx),
        .word (mgmt_wdata),
        .addr (mgmt_addr)
    );

    errlog_pend_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .np_issue (np_issue),
        .np_cpl   (np_cpl),
        .cpl_pend (cpl_pend)
    );

    // R4: an unacknowledged write holds strobe, address and data
    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mgmt_wr && !mgmt_ack) |=> (mgmt_wr && $stable(mgmt_addr) && $stable(mgmt_wdata)));
    // R3: an acknowledge that is not the last one moves to the next address
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (mgmt_wr && mgmt_ack && mgmt_addr != ADDR_W'(BASE_ADDR) + ADDR_W'((WORDS-1)*ADDR_STEP))
        |=> (mgmt_wr && mgmt_addr == $past(mgmt_addr) + ADDR_W'(ADDR_STEP)));
    // R5: flags follow the last acknowledged write
    assert_flag_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        err_flags[LOG_BIT] |-> $past(mgmt_wr && mgmt_ack));
endmodule

// File: tb/sim_errlog_seq.sv
module sim_errlog_seq;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid, req_log, mgmt_ack, np_issue, np_cpl;
    logic [1:0]   req_kind;
    logic [127:0] req_hdr;
    logic         busy, done, mgmt_wr, cpl_pend;
    logic [11:0]  mgmt_addr;
    logic [31:0]  mgmt_wdata;
    logic [6:0]   err_flags;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    errlog_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_log(req_log), .req_hdr(req_hdr), .busy(busy), .done(done),
        .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata), .mgmt_wr(mgmt_wr),
        .mgmt_ack(mgmt_ack), .err_flags(err_flags), .np_issue(np_issue),
        .np_cpl(np_cpl), .cpl_pend(cpl_pend)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; req_kind = '0; req_log = 1'b0;
        req_hdr = '0; mgmt_ack = 1'b0; np_issue = 1'b0; np_cpl = 1'b0;
        repeat (3) step();
        chk("R1", "busy in reset", busy, 1'b0);
        chk("R1", "flags in reset", err_flags, 7'd0);
        rst = 1'b0;
        step();
        chk("R1", "busy", busy, 1'b0);
        chk("R1", "done", done, 1'b0);
        chk("R1", "wr", mgmt_wr, 1'b0);
        chk("R1", "pend", cpl_pend, 1'b0);
        chk("R1", "flags", err_flags, 7'd0);
    endtask

    // logged report; wait = cycles before each ack; poke keeps a stray request up
    task automatic t_logged(input logic [1:0] kind, input logic [127:0] hdr,
                            input int wait_cyc, input bit poke);
        logic [6:0] exp_flags;
        exp_flags = 7'd0;
        exp_flags[2 + int'(kind)] = 1'b1;
        exp_flags[6] = 1'b1;
        req_valid = 1'b1; req_kind = kind; req_log = 1'b1; req_hdr = hdr;
        step();
        if (poke) begin
            req_kind = kind + 2'd1; req_log = 1'b0; req_hdr = ~hdr;
        end else begin
            req_valid = 1'b0;
        end
        for (int w = 0; w < 4; w++) begin
            for (int d = 0; d < wait_cyc; d++) begin
                chk("R4", "wr held", mgmt_wr, 1'b1);
                chk("R4", "addr held", mgmt_addr, 12'h81C + 12'(4*w));
                chk("R4", "data held", mgmt_wdata, hdr[127-32*w -: 32]);
                chk("R5", "no early flags", err_flags, 7'd0);
                step();
            end
            chk("R3", "wr", mgmt_wr, 1'b1);
            chk("R3", "addr", mgmt_addr, 12'h81C + 12'(4*w));
            chk("R3", "data", mgmt_wdata, hdr[127-32*w -: 32]);
            chk("R5", "no flags before last ack", err_flags, 7'd0);
            chk("R2", "busy during write", busy, 1'b1);
            mgmt_ack = 1'b1;
            step();
            mgmt_ack = 1'b0;
        end
        chk("R5", "flags after last ack", err_flags, exp_flags);
        chk("R6", "flag kind", err_flags, exp_flags);
        chk("R5", "wr low in flag cycle", mgmt_wr, 1'b0);
        chk("R8", "no done in flag cycle", done, 1'b0);
        step();
        req_valid = 1'b0;
        chk("R8", "done", done, 1'b1);
        chk("R5", "flags one cycle", err_flags, 7'd0);
        step();
        chk("R8", "idle after done", busy, 1'b0);
        chk("R8", "done pulse", done, 1'b0);
        chk("R2", "no stray report", mgmt_wr, 1'b0);
        step();
        chk("R2", "still idle", busy, 1'b0);
    endtask

    task automatic t_nolog(input logic [1:0] kind);
        logic [6:0] exp_flags;
        exp_flags = 7'd0;
        exp_flags[2 + int'(kind)] = 1'b1;
        req_valid = 1'b1; req_kind = kind; req_log = 1'b0; req_hdr = {4{32'hDEAD_BEEF}};
        step();
        req_valid = 1'b0;
        chk("R7", "flag without log", err_flags, exp_flags);
        chk("R7", "no write", mgmt_wr, 1'b0);
        chk("R2", "busy", busy, 1'b1);
        step();
        chk("R8", "done", done, 1'b1);
        chk("R7", "flag gone", err_flags, 7'd0);
        chk("R7", "no write later", mgmt_wr, 1'b0);
        step();
        chk("R8", "idle", busy, 1'b0);
    endtask

    task automatic t_counter();
        chk("R9", "pend at zero", cpl_pend, 1'b0);
        np_issue = 1'b1; np_cpl = 1'b1;
        step();
        chk("R9", "both at zero", cpl_pend, 1'b0);
        np_cpl = 1'b0;
        step();
        chk("R9", "one issued", cpl_pend, 1'b1);
        np_cpl = 1'b1;
        step();
        chk("R9", "both at one", cpl_pend, 1'b1);
        np_issue = 1'b0;
        step();
        chk("R9", "completed", cpl_pend, 1'b0);
        np_cpl = 1'b0; np_issue = 1'b1;
        repeat (20) step();
        np_issue = 1'b0; np_cpl = 1'b1;
        repeat (14) step();
        chk("R10", "top saturation, 14 back", cpl_pend, 1'b1);
        step();
        chk("R10", "top saturation, 15 back", cpl_pend, 1'b0);
        repeat (3) step();
        np_cpl = 1'b0; np_issue = 1'b1;
        step();
        np_issue = 1'b0;
        chk("R10", "zero saturation, one up", cpl_pend, 1'b1);
        np_cpl = 1'b1;
        step();
        np_cpl = 1'b0;
        chk("R10", "zero saturation, back", cpl_pend, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_logged(2'd2, 128'h11223344_55667788_99AABBCC_DDEEFF00, 0, 1'b0);
        t_logged(2'd0, 128'hCAFE0001_BEEF0002_F00D0003_0BAD0004, 2, 1'b1);
        t_logged(2'd3, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1, 1'b0);
        t_nolog(2'd1);
        t_nolog(2'd3);
        t_counter();
        finish_run();
    end
endmodule